// File: doc/BRIEF.md
# Stimulus Coprocessor with Timed Interrupt Lines

This block answers a CPU's coprocessor command port on two coprocessor numbers (4 and 5 by default) and serves a bank of sixteen 32-bit registers. Register moves in both directions work on either number. Word loads and stores work on the lower number only. A data-operation command has no arithmetic meaning here; it acts as test stimulus. It can stall the CPU for a number of cycles held in a register. It can make the active-low fast or normal interrupt line fall after a programmed delay, or raise either line again. It can also copy a free-running cycle counter into a register.

Each cycle that `cmd_valid` is high and `busy` is low completes one step of a command. While `busy` is high the CPU holds the same command on the port. `cant` reports a command that the block will not carry out, and the CPU turns it into an undefined-instruction trap. A state machine with three states sequences the multi-cycle cases. IDLE takes each new command. IDLE goes to LONG when a two-word load or store is accepted, and LONG goes back to IDLE after the second word. IDLE goes to WAIT when a busy-wait starts with time still to run. WAIT goes back to IDLE when the cycle counter reaches the finish time or when the command is withdrawn.

Top module: `cpx_test_unit`

## Requirements
- R1: After reset, all sixteen registers read 0, `fiq_n` and `irq_n` are 1, and `busy` is 0.
- R2: `cmd_kind` 0 writes `cmd_wdata` into the register at instruction bits 19:16, and `cmd_kind` 1 returns that register on `rdata` in the same cycle. Both kinds give access to the one shared bank on either coprocessor number.
- R3: `cmd_kind` 2 (load) and `cmd_kind` 3 (store) on coprocessor 4 move one word to or from the register at bits 15:12 when bit 22 is 0, and `busy` stays 0.
- R4: When bit 22 is 1, a load or store takes two cycles. `busy` is 1 in the first cycle, which moves the register at bits 15:12. `busy` is 0 in the second cycle, which moves the register after it, wrapping from 15 to 0.
- R5: `cmd_kind` 4 (data operation) with opcode 0 in bits 23:20, on either number, holds `busy` at 1 for exactly N cycles, where N is the register at bits 3:0 (N below 2^31). The counter comparison is wrap-safe.
- R6: Opcode 1 on coprocessor 5 makes `fiq_n` fall at the N-th clock edge after the edge that ends the command, where N is the register at bits 3:0. When N is 0, it falls at the edge that ends the command.
- R7: Opcode 2 on coprocessor 5 does the same for `irq_n`.
- R8: Opcode 3 on coprocessor 5 drives `fiq_n` high and cancels any pending fast delay. Opcode 4 does the same for `irq_n`.
- R9: A new delay issued while one is pending replaces it, and timing runs from the new command.
- R10: Opcode 5 on coprocessor 5 writes the cycle counter, which steps by 1 per clock, into the register at bits 3:0. Two such captures taken k cycles apart differ by k.
- R11: `cant` is 1, and no register or line changes, in each of these cases: a number other than 4 or 5; a load or store on coprocessor 5; any opcode other than 0 on coprocessor 4; an opcode above 5 on coprocessor 5; a `cmd_kind` above 4. `busy` is 0 whenever `cant` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_cpnum | input | 4 | Coprocessor number addressed |
| cmd_kind | input | 3 | 0 write reg, 1 read reg, 2 load, 3 store, 4 data operation |
| cmd_instr | input | 32 | Instruction word carrying indices, length bit and opcode |
| cmd_wdata | input | 32 | Data from CPU for register writes and loads |
| rdata | output | 32 | Data to CPU for register reads and stores |
| busy | output | 1 | Hold the command another cycle |
| cant | output | 1 | Command not handled |
| fiq_n | output | 1 | Active-low fast interrupt request |
| irq_n | output | 1 | Active-low normal interrupt request |

## Verification
Every register is written through one coprocessor number and read back through the other, with distinct values per index, so a wrong index field or a split bank shows up. The busy-wait and both delayed lines are swept over counts 0 to 7, and the edge at which busy ends or a line falls must match the count exactly, which separates off-by-one timing from correct timing. Two-word transfers start at register 15 to expose a missing wrap. The rejected-command cases are each followed by a read-back or a line watch, so that a command which is flagged but still acts is caught.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
    typedef enum logic [2:0] {
        K_WRREG = 3'd0,
        K_RDREG = 3'd1,
        K_LOAD  = 3'd2,
        K_STORE = 3'd3,
        K_DOP   = 3'd4
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LONG = 2'd1,
        ST_WAIT = 2'd2
    } cpx_state_e;

    localparam logic [3:0] OP_STALL   = 4'd0;
    localparam logic [3:0] OP_FAST_ON = 4'd1;
    localparam logic [3:0] OP_NORM_ON = 4'd2;
    localparam logic [3:0] OP_FAST_OF = 4'd3;
    localparam logic [3:0] OP_NORM_OF = 4'd4;
    localparam logic [3:0] OP_STAMP   = 4'd5;
endpackage

// File: rtl/cpx_regfile.sv
module cpx_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata = regs[raddr];
endmodule

// File: rtl/cpx_irq_timer.sv
module cpx_irq_timer #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [DW-1:0] delay,
    input  logic          drop,
    output logic          line_n
);
    logic          pending;
    logic [DW-1:0] left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_n  <= 1'b1;
            pending <= 1'b0;
            left    <= '0;
        end else if (drop) begin
            line_n  <= 1'b1;
            pending <= 1'b0;
        end else if (arm) begin
            if (delay == '0) begin
                line_n  <= 1'b0;
                pending <= 1'b0;
            end else begin
                pending <= 1'b1;
                left    <= delay;
            end
        end else if (pending) begin
            if (left == DW'(1)) begin
                line_n  <= 1'b0;
                pending <= 1'b0;
            end else begin
                left <= left - DW'(1);
            end
        end
    end

    assert_zero_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !drop && delay == '0) |=> !line_n);

    assert_drop_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> line_n);
endmodule

// File: rtl/cpx_test_unit.sv
module cpx_test_unit
    import cpx_pkg::*;
#(
    parameter int         DW   = 32,
    parameter int         NREG = 16,
    parameter logic [3:0] CP_A = 4'd4,
    parameter logic [3:0] CP_B = 4'd5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_cpnum,
    input  logic [2:0]    cmd_kind,
    input  logic [31:0]   cmd_instr,
    input  logic [DW-1:0] cmd_wdata,
    output logic [DW-1:0] rdata,
    output logic          busy,
    output logic          cant,
    output logic          fiq_n,
    output logic          irq_n
);
    localparam int AW   = $clog2(NREG);
    localparam int NTMR = 2;

    cpx_state_e    state_q, state_d;
    logic [DW-1:0] cycles_q;
    logic [DW-1:0] finish_q, finish_d;

    cmd_kind_e     kind;
    logic          on_a, on_b, legal, acc, is_long;
    logic [3:0]    opc;
    logic [AW-1:0] idx_rt, idx_ls, idx_ls_next, idx_dop;
    logic [AW-1:0] rf_raddr, rf_waddr;
    logic [DW-1:0] rf_rdata, rf_wdata;
    logic          rf_we;
    logic [DW-1:0] gap_now, gap_first;
    logic          more_now, more_first;
    logic          t_arm  [NTMR];
    logic          t_drop [NTMR];
    logic          t_line [NTMR];

    assign kind        = cmd_kind_e'(cmd_kind);
    assign on_a        = (cmd_cpnum == CP_A);
    assign on_b        = (cmd_cpnum == CP_B);
    assign opc         = cmd_instr[23:20];
    assign is_long     = cmd_instr[22];
    assign idx_rt      = cmd_instr[16 +: AW];
    assign idx_ls      = cmd_instr[12 +: AW];
    assign idx_ls_next = idx_ls + AW'(1);
    assign idx_dop     = cmd_instr[0 +: AW];

    always_comb begin
        case (kind)
            K_WRREG, K_RDREG: legal = on_a || on_b;
            K_LOAD, K_STORE:  legal = on_a;
            K_DOP:            legal = on_a ? (opc == OP_STALL)
                                           : (on_b && opc <= OP_STAMP);
            default:          legal = 1'b0;
        endcase
    end

    assign acc  = cmd_valid && legal;
    assign cant = cmd_valid && !legal;

    // wrap-safe remaining-time tests
    assign gap_now    = cycles_q - finish_q;
    assign more_now   = gap_now[DW-1];
    assign gap_first  = cycles_q - (cycles_q + rf_rdata);
    assign more_first = gap_first[DW-1];

    always_comb begin
        case (kind)
            K_RDREG: rf_raddr = idx_rt;
            K_STORE: rf_raddr = (state_q == ST_LONG) ? idx_ls_next : idx_ls;
            default: rf_raddr = idx_dop;
        endcase
    end

    cpx_regfile #(.DW(DW), .NREG(NREG)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) cycles_q <= '0;
        else        cycles_q <= cycles_q + DW'(1);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            finish_q <= '0;
        end else begin
            state_q  <= state_d;
            finish_q <= finish_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        finish_d = finish_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc && (kind == K_LOAD || kind == K_STORE) && is_long)
                    state_d = ST_LONG;
                else if (acc && kind == K_DOP && opc == OP_STALL && more_first) begin
                    state_d  = ST_WAIT;
                    finish_d = cycles_q + rf_rdata;
                end
            end
            ST_LONG: state_d = ST_IDLE;
            ST_WAIT: if (!cmd_valid || !more_now) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        rdata    = '0;
        rf_we    = 1'b0;
        rf_waddr = idx_dop;
        rf_wdata = cmd_wdata;
        for (int t = 0; t < NTMR; t++) begin
            t_arm[t]  = 1'b0;
            t_drop[t] = 1'b0;
        end
        unique case (state_q)
            ST_IDLE: begin
                if (acc) begin
                    unique case (kind)
                        K_WRREG: begin
                            rf_we    = 1'b1;
                            rf_waddr = idx_rt;
                        end
                        K_RDREG: rdata = rf_rdata;
                        K_LOAD: begin
                            rf_we    = 1'b1;
                            rf_waddr = idx_ls;
                            busy     = is_long;
                        end
                        K_STORE: begin
                            rdata = rf_rdata;
                            busy  = is_long;
                        end
                        K_DOP: begin
                            busy      = (opc == OP_STALL) && more_first;
                            t_arm[0]  = on_b && opc == OP_FAST_ON;
                            t_arm[1]  = on_b && opc == OP_NORM_ON;
                            t_drop[0] = on_b && opc == OP_FAST_OF;
                            t_drop[1] = on_b && opc == OP_NORM_OF;
                            if (on_b && opc == OP_STAMP) begin
                                rf_we    = 1'b1;
                                rf_wdata = cycles_q;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_LONG: begin
                if (acc && kind == K_LOAD) begin
                    rf_we    = 1'b1;
                    rf_waddr = idx_ls_next;
                end
                if (acc && kind == K_STORE) rdata = rf_rdata;
            end
            ST_WAIT: busy = cmd_valid && more_now;
            default: ;
        endcase
    end

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        cpx_irq_timer #(.DW(DW)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm    (t_arm[g]),
            .delay  (rf_rdata),
            .drop   (t_drop[g]),
            .line_n (t_line[g])
        );
    end

    assign fiq_n = t_line[0];
    assign irq_n = t_line[1];

    assert_unserved_cant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_cpnum != CP_A && cmd_cpnum != CP_B) |-> cant);

    assert_cant_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cant |-> !busy);

    assert_long_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy && (kind == K_LOAD || kind == K_STORE)) |=> !busy);

    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cycles_q == $past(cycles_q) + DW'(1));
endmodule

// File: tb/cpx_test_unit_tb.sv
`timescale 1ns/1ps
module cpx_test_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_cpnum = '0;
    logic [2:0]  cmd_kind = '0;
    logic [31:0] cmd_instr = '0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] rdata;
    logic        busy, cant, fiq_n, irq_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] s_rd;
    logic        s_busy, s_cant;

    always #2 clk = ~clk;

    cpx_test_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_cpnum(cmd_cpnum),
        .cmd_kind(cmd_kind), .cmd_instr(cmd_instr), .cmd_wdata(cmd_wdata),
        .rdata(rdata), .busy(busy), .cant(cant), .fiq_n(fiq_n), .irq_n(irq_n)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_rt(input int r);
        return 32'(r & 15) << 16;
    endfunction
    function automatic logic [31:0] f_ls(input int r, input bit lng);
        return (32'(lng) << 22) | (32'(r & 15) << 12);
    endfunction
    function automatic logic [31:0] f_dop(input int op, input int r);
        return (32'(op & 15) << 20) | 32'(r & 15);
    endfunction
    function automatic logic [31:0] pat(input int i);
        return (32'(i) * 32'h0101_0101) ^ 32'h5A00_C300;
    endfunction

    task automatic step(input int kind, input int cp, input logic [31:0] ins, input logic [31:0] wd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 3'(kind); cmd_cpnum = 4'(cp);
        cmd_instr = ins; cmd_wdata = wd;
        #1;
        s_rd = rdata; s_busy = busy; s_cant = cant;
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
    endtask

    task automatic wr(input int cp, input int r, input logic [31:0] d);
        step(0, cp, f_rt(r), d);
    endtask

    task automatic rd(input int cp, input int r, output logic [31:0] v);
        step(1, cp, f_rt(r), 32'h0);
        v = s_rd;
    endtask

    // arms a line and returns the negedge index at which it is first low
    task automatic arm_measure(input int op, input int n, input bit fast, output int k);
        logic l;
        wr(5, 9, 32'(n));
        step(4, 5, f_dop(op, 9), 32'h0);
        k = 0;
        l = 1'b1;
        while (l && k < 40) begin
            idle();
            k++;
            l = fast ? fiq_n : irq_n;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int nb, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        check(fiq_n === 1'b1 && irq_n === 1'b1 && busy === 1'b0, "R1 reset lines", {29'b0, fiq_n, irq_n, busy}, 32'h6);
        for (int i = 0; i < 16; i++) begin
            rd(4, i, v);
            check(v === 32'h0, "R1 reset reg", v, 32'h0);
        end
        // R2: write via one number, read via the other
        for (int i = 0; i < 16; i++) wr(4, i, pat(i));
        for (int i = 0; i < 16; i++) begin
            rd(5, i, v);
            check(v === pat(i) && s_cant === 1'b0, "R2 cross read", v, pat(i));
        end
        wr(5, 6, 32'hDEAD_0006);
        rd(4, 6, v);
        check(v === 32'hDEAD_0006, "R2 cp5 write", v, 32'hDEAD_0006);
        // R3 short load/store
        step(2, 4, f_ls(3, 1'b0), 32'h1234_5678);
        check(s_busy === 1'b0, "R3 short load busy", 32'(s_busy), 32'h0);
        rd(4, 3, v);
        check(v === 32'h1234_5678, "R3 load value", v, 32'h1234_5678);
        step(3, 4, f_ls(3, 1'b0), 32'h0);
        check(s_rd === 32'h1234_5678 && s_busy === 1'b0, "R3 store value", s_rd, 32'h1234_5678);
        // R4 long load from 15 wraps to 0
        step(2, 4, f_ls(15, 1'b1), 32'hAAAA_0015);
        check(s_busy === 1'b1, "R4 long first busy", 32'(s_busy), 32'h1);
        step(2, 4, f_ls(15, 1'b1), 32'hBBBB_0000);
        check(s_busy === 1'b0, "R4 long second busy", 32'(s_busy), 32'h0);
        rd(4, 15, v);
        check(v === 32'hAAAA_0015, "R4 long word0", v, 32'hAAAA_0015);
        rd(4, 0, v);
        check(v === 32'hBBBB_0000, "R4 long word1 wrap", v, 32'hBBBB_0000);
        step(3, 4, f_ls(15, 1'b1), 32'h0);
        check(s_rd === 32'hAAAA_0015 && s_busy === 1'b1, "R4 long store word0", s_rd, 32'hAAAA_0015);
        step(3, 4, f_ls(15, 1'b1), 32'h0);
        check(s_rd === 32'hBBBB_0000 && s_busy === 1'b0, "R4 long store word1", s_rd, 32'hBBBB_0000);
        idle();
        // R5 busy-wait sweep on both numbers
        for (int cp = 4; cp <= 5; cp++) begin
            for (int n = 0; n < 8; n++) begin
                wr(cp, 2, 32'(n));
                step(4, cp, f_dop(0, 2), 32'h0);
                nb = 0;
                while (s_busy && nb < 100) begin
                    nb++;
                    @(negedge clk);
                    #1;
                    s_busy = busy;
                end
                check(nb == n, "R5 stall length", 32'(nb), 32'(n));
                idle();
            end
        end
        // R6 / R7 delay sweeps
        for (int n = 0; n < 8; n++) begin
            arm_measure(1, n, 1'b1, k);
            check(k == n + 1, "R6 fiq delay", 32'(k), 32'(n + 1));
            step(4, 5, f_dop(3, 0), 32'h0);
            idle();
            check(fiq_n === 1'b1, "R8 fiq release", 32'(fiq_n), 32'h1);
            arm_measure(2, n, 1'b0, k);
            check(k == n + 1, "R7 irq delay", 32'(k), 32'(n + 1));
            step(4, 5, f_dop(4, 0), 32'h0);
            idle();
            check(irq_n === 1'b1, "R8 irq release", 32'(irq_n), 32'h1);
        end
        // R8 release cancels a pending delay
        wr(5, 9, 32'd5);
        step(4, 5, f_dop(1, 9), 32'h0);
        step(4, 5, f_dop(3, 0), 32'h0);
        nb = 0;
        for (int i = 0; i < 12; i++) begin
            idle();
            if (fiq_n !== 1'b1) nb++;
        end
        check(nb == 0, "R8 cancel pending", 32'(nb), 32'h0);
        // R9 replacement: long delay then short delay
        wr(5, 10, 32'd12);
        step(4, 5, f_dop(2, 10), 32'h0);
        arm_measure(2, 2, 1'b0, k);
        check(k == 3, "R9 replaced delay", 32'(k), 32'h3);
        step(4, 5, f_dop(4, 0), 32'h0);
        wr(5, 10, 32'd3);
        step(4, 5, f_dop(2, 10), 32'h0);
        arm_measure(2, 9, 1'b0, k);
        check(k == 10, "R9 lengthened delay", 32'(k), 32'd10);
        step(4, 5, f_dop(4, 0), 32'h0);
        idle();
        // R10 timestamps
        step(4, 5, f_dop(5, 7), 32'h0);
        step(4, 5, f_dop(5, 8), 32'h0);
        rd(5, 7, v); rd(5, 8, v2);
        check(v2 - v == 32'd1, "R10 back to back", v2 - v, 32'd1);
        step(4, 5, f_dop(5, 7), 32'h0);
        idle(); idle(); idle();
        step(4, 5, f_dop(5, 8), 32'h0);
        rd(5, 7, v); rd(5, 8, v2);
        check(v2 - v == 32'd4, "R10 spaced", v2 - v, 32'd4);
        // R11 rejected commands
        wr(4, 11, 32'h0000_B0B0);
        step(0, 3, f_rt(11), 32'hFFFF_FFFF);
        check(s_cant === 1'b1 && s_busy === 1'b0, "R11 cp3 cant", 32'(s_cant), 32'h1);
        step(0, 15, f_rt(11), 32'hFFFF_FFFF);
        check(s_cant === 1'b1, "R11 cp15 cant", 32'(s_cant), 32'h1);
        step(2, 5, f_ls(11, 1'b0), 32'hFFFF_FFFF);
        check(s_cant === 1'b1 && s_busy === 1'b0, "R11 cp5 load cant", 32'(s_cant), 32'h1);
        step(7, 4, f_rt(11), 32'hFFFF_FFFF);
        check(s_cant === 1'b1, "R11 bad kind cant", 32'(s_cant), 32'h1);
        rd(4, 11, v);
        check(v === 32'h0000_B0B0 && s_cant === 1'b0, "R11 reg untouched", v, 32'h0000_B0B0);
        wr(4, 1, 32'd0);
        step(4, 4, f_dop(1, 1), 32'h0);
        check(s_cant === 1'b1, "R11 cp4 op1 cant", 32'(s_cant), 32'h1);
        step(4, 5, f_dop(6, 1), 32'h0);
        check(s_cant === 1'b1, "R11 cp5 op6 cant", 32'(s_cant), 32'h1);
        idle(); idle();
        check(fiq_n === 1'b1 && irq_n === 1'b1, "R11 lines untouched", {30'b0, fiq_n, irq_n}, 32'h3);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule